// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical address for one access at a time. It first compares the access with two transparent windows. A hit passes the address through unchanged in one cycle. On a miss it reads a root descriptor, then a pointer descriptor, then a page descriptor from memory through a single 32-bit read port, and builds the physical address from the page frame and the page offset. The page size is set by an input and is either 4 KB or 8 KB.

Both windows and the root and pointer descriptors can mark a region write-protected. A write to such a region ends with a bus error. A test-only (probe) access still walks the tables, but protection and invalid entries do not make it fault. A page descriptor may point to a second descriptor that holds the frame. The walker follows at most a fixed number of these indirect hops, so it cannot loop forever. Whenever an access ends in a fault, or a probe stops at an invalid entry, the reported address is the logical address itself.

Top module: `xw_walker`

## Requirements
- R1: After reset, `done`, `bus_err` and `mem_req` are 0 and stay 0 until a request arrives.
- R2: A window is enabled by its bit 15. It matches when logical address bits 31:24 equal window bits 31:24 in every position where the mask in window bits 23:16 is 0. Window bits 14:13 choose the function-code rule: 0 accepts only fc[2]=0, 1 accepts only fc[2]=1, and 2 or 3 accept any code. On a hit, `done` rises in the cycle after the request is accepted, `phys_addr` equals the logical address, and no memory read is issued.
- R3: If the matching window has bit 2 set and `req_wr`=1 with `req_probe`=0, the access ends with `bus_err`=1. A probe of the same access ends with `bus_err`=0.
- R4: On a window miss, the root descriptor is read at {root_ptr[31:9], va[31:25], 2'b00}. The pointer descriptor is read at {root descriptor[31:9], va[24:18], 2'b00}.
- R5: With `big_page`=0 (4 KB), the page descriptor is read at {pointer[31:8], va[17:12], 2'b00}, and a resident page gives {page[31:12], va[11:0]}.
- R6: With `big_page`=1 (8 KB), the page descriptor is read at {pointer[31:7], va[17:13], 2'b00}, and a resident page gives {page[31:13], va[12:0]}.
- R7: A root or pointer descriptor is valid only when its bit 1 is 1. An invalid one ends the access with `bus_err`=1, or with `bus_err`=0 for a probe. In both cases `phys_addr` equals the logical address.
- R8: A root or pointer descriptor with bit 2 set ends a non-probe write with `bus_err`=1. A read through it, or a probe write through it, completes the translation normally.
- R9: The type of a page descriptor is held in its bits 1:0. Types 1 and 3 are resident. Type 0 is invalid and ends the access with `bus_err`=1 (0 for a probe) and `phys_addr` equal to the logical address.
- R10: Type 2 is indirect: the walker reads the next descriptor at {descriptor[31:2], 2'b00}. After MAX_IND such hops (default 1), a further type 2 ends the access with `bus_err`=1, even for a probe.
- R11: `done` is a one-cycle pulse. `mem_req` drops when `done` is high. While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` does not change. `bus_err` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Starts an access when the walker is idle |
| req_addr | input | 32 | Logical address |
| req_fc | input | 3 | Function code; bit 2 marks supervisor |
| req_wr | input | 1 | 1 for a write access |
| req_probe | input | 1 | Test-only access: no protection or invalid fault |
| root_ptr | input | 32 | Root table base; low 9 bits ignored |
| big_page | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB |
| win0 | input | 32 | Transparent window 0 (checked first) |
| win1 | input | 32 | Transparent window 1 |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 32 | Descriptor read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse when the result is valid |
| phys_addr | output | 32 | Physical address, held until the next result |
| bus_err | output | 1 | Access faulted, held until the next result |

## Verification
An internal fault in this block shows up at the ports as a wrong memory read address, or as a walk that takes a different number of reads than expected. An index taken from the wrong address field, or a wrongly cleared base, sends the next read to an unprogrammed word, so the access ends with an unexpected bus error within one to three reads. An error in page-size selection or indirect handling shows up only in `phys_addr` or in the read count when `done` pulses. The bench therefore checks the physical address, the error flag and the number of reads for each access. A window decode error shows up in the first cycle: either `done` comes late, or memory reads appear where none should happen.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W  = 32;
    localparam int HOP_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROOT,
        ST_PTR,
        ST_PAGE
    } walk_st_e;

    typedef struct packed {
        walk_st_e          st;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              probe;
        logic              rd;
        logic [VA_W-1:0]   maddr;
        logic [HOP_W-1:0]  hops;
        logic              done;
        logic              err;
        logic [VA_W-1:0]   pa;
    } walk_regs_t;

    // function-code acceptance by window mode
    function automatic logic fc_accept(input logic [1:0] mode, input logic [2:0] fc);
        unique case (mode)
            2'd0:    fc_accept = ~fc[2];
            2'd1:    fc_accept = fc[2];
            default: fc_accept = 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/xw_window.sv
module xw_window
    import xw_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [2:0]      fc,
    input  logic            wr,
    input  logic            probe,
    input  logic [31:0]     win,
    output logic            hit,
    output logic            fault
);
    logic [7:0] base, ign;
    logic       addr_ok;

    assign base    = win[31:24];
    assign ign     = win[23:16];
    assign addr_ok = ((va[VA_W-1 -: 8] ^ base) & ~ign) == 8'h00;
    assign hit     = win[15] & addr_ok & fc_accept(win[14:13], fc);
    assign fault   = hit & win[2] & wr & ~probe;
endmodule

// File: rtl/xw_pgcalc.sv
module xw_pgcalc
    import xw_pkg::*;
#(
    parameter int IDX_TOP  = 17,
    parameter int SMALL_SH = 12
) (
    input  logic [VA_W-1:0] va,
    input  logic [31:0]     desc,
    input  logic            big_page,
    output logic [31:0]     pg_desc_addr,
    output logic [31:0]     phys
);
    localparam int BIG_SH  = SMALL_SH + 1;
    localparam int S_IDX_W = IDX_TOP - SMALL_SH + 1;
    localparam int B_IDX_W = IDX_TOP - BIG_SH + 1;

    always_comb begin
        if (big_page) begin
            pg_desc_addr = {desc[31:B_IDX_W+2], va[IDX_TOP -: B_IDX_W], 2'b00};
            phys         = {desc[31:BIG_SH], va[BIG_SH-1:0]};
        end else begin
            pg_desc_addr = {desc[31:S_IDX_W+2], va[IDX_TOP -: S_IDX_W], 2'b00};
            phys         = {desc[31:SMALL_SH], va[SMALL_SH-1:0]};
        end
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
#(
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int SMALL_SH   = 12,
    parameter int MAX_IND    = 1,
    parameter int N_WIN      = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [2:0]  req_fc,
    input  logic        req_wr,
    input  logic        req_probe,
    input  logic [31:0] root_ptr,
    input  logic        big_page,
    input  logic [31:0] win0,
    input  logic [31:0] win1,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [31:0] phys_addr,
    output logic        bus_err
);
    localparam int PIDX_TOP = VA_W - 1 - ROOT_IDX_W;
    localparam int IDX_TOP  = PIDX_TOP - PTR_IDX_W;
    localparam logic [HOP_W-1:0] HOP_CAP = HOP_W'(MAX_IND);

    walk_regs_t r_q, r_d;

    logic [31:0]      win_cfg [N_WIN];
    logic [N_WIN-1:0] w_hit, w_fault;
    logic             any_hit, hit_fault;
    logic [31:0]      pg_desc_addr, pg_phys;

    assign win_cfg[0] = win0;
    assign win_cfg[1] = win1;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        xw_window u_win (
            .va   (req_addr),
            .fc   (req_fc),
            .wr   (req_wr),
            .probe(req_probe),
            .win  (win_cfg[g]),
            .hit  (w_hit[g]),
            .fault(w_fault[g])
        );
    end

    // lowest-numbered matching window decides protection
    always_comb begin
        any_hit   = |w_hit;
        hit_fault = 1'b0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (w_hit[i]) hit_fault = w_fault[i];
        end
    end

    xw_pgcalc #(.IDX_TOP(IDX_TOP), .SMALL_SH(SMALL_SH)) u_pg (
        .va          (r_q.va),
        .desc        (mem_rdata),
        .big_page    (big_page),
        .pg_desc_addr(pg_desc_addr),
        .phys        (pg_phys)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va    = req_addr;
                    r_d.wr    = req_wr;
                    r_d.probe = req_probe;
                    r_d.hops  = '0;
                    if (any_hit) begin
                        r_d.done = 1'b1;
                        r_d.err  = hit_fault;
                        r_d.pa   = req_addr;
                    end else begin
                        r_d.rd    = 1'b1;
                        r_d.maddr = {root_ptr[31:ROOT_IDX_W+2],
                                     req_addr[VA_W-1 -: ROOT_IDX_W], 2'b00};
                        r_d.st    = ST_ROOT;
                    end
                end
            end
            ST_ROOT, ST_PTR: begin
                if (mem_ack) begin
                    if (!mem_rdata[1] || (mem_rdata[2] && r_q.wr && !r_q.probe)) begin
                        r_d.done = 1'b1;
                        r_d.rd   = 1'b0;
                        r_d.err  = !r_q.probe;
                        r_d.pa   = r_q.va;
                        r_d.st   = ST_IDLE;
                    end else if (r_q.st == ST_ROOT) begin
                        r_d.maddr = {mem_rdata[31:PTR_IDX_W+2],
                                     r_q.va[PIDX_TOP -: PTR_IDX_W], 2'b00};
                        r_d.st    = ST_PTR;
                    end else begin
                        r_d.maddr = pg_desc_addr;
                        r_d.st    = ST_PAGE;
                    end
                end
            end
            ST_PAGE: begin
                if (mem_ack) begin
                    if (mem_rdata[1:0] == 2'd2 && r_q.hops != HOP_CAP) begin
                        r_d.hops  = r_q.hops + 1'b1;
                        r_d.maddr = {mem_rdata[31:2], 2'b00};
                    end else begin
                        r_d.done = 1'b1;
                        r_d.rd   = 1'b0;
                        r_d.st   = ST_IDLE;
                        if (mem_rdata[1:0] == 2'd2) begin
                            r_d.err = 1'b1;
                            r_d.pa  = r_q.va;
                        end else if (mem_rdata[1:0] == 2'd0) begin
                            r_d.err = !r_q.probe;
                            r_d.pa  = r_q.va;
                        end else begin
                            r_d.err = 1'b0;
                            r_d.pa  = pg_phys;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = r_q.rd;
    assign mem_addr  = r_q.maddr;
    assign done      = r_q.done;
    assign phys_addr = r_q.pa;
    assign bus_err   = r_q.err;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        done,
    input logic        bus_err
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R11
    done_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(bus_err) || done));
    // R1
    idle_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_req && !bus_err));
endmodule

bind xw_walker xw_walker_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .done    (done),
    .bus_err (bus_err)
);

// File: tb/xw_walker_tb.sv
module xw_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic        req_wr = 1'b0;
    logic        req_probe = 1'b0;
    logic [31:0] root_ptr = '0;
    logic        big_page = 1'b0;
    logic [31:0] win0 = '0;
    logic [31:0] win1 = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] phys_addr;
    logic        bus_err;

    logic [31:0] mem [0:4095];
    int          reads_total = 0;
    int          n_total = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_fc(req_fc), .req_wr(req_wr), .req_probe(req_probe),
        .root_ptr(root_ptr), .big_page(big_page), .win0(win0), .win1(win1),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .phys_addr(phys_addr),
        .bus_err(bus_err)
    );

    // memory answers one cycle after a request, one beat per request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            mem_ack     <= 1'b1;
            mem_rdata   <= mem[mem_addr[13:2]];
            reads_total <= reads_total + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] va, input logic [2:0] fc, input logic wr,
                          input logic probe, output logic [31:0] pa, output logic err,
                          output int lat, output int nrd);
        int r0;
        @(negedge clk);
        r0        = reads_total;
        req_addr  = va;
        req_fc    = fc;
        req_wr    = wr;
        req_probe = probe;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        pa  = phys_addr;
        err = bus_err;
        nrd = reads_total - r0;
    endtask

    task automatic expect_walk(input string tag, input logic [31:0] va, input logic [2:0] fc,
                               input logic wr, input logic probe, input logic [31:0] exp_pa,
                               input logic exp_err, input int exp_rd);
        logic [31:0] pa;
        logic        err;
        int          lat, nrd;
        access(va, fc, wr, probe, pa, err, lat, nrd);
        check({tag, " phys"}, pa, exp_pa);
        check({tag, " err"}, 32'(err), 32'(exp_err));
        check({tag, " reads"}, 32'(nrd), 32'(exp_rd));
    endtask

    task automatic t_reset;
        check("R1 done", 32'(done), 0);
        check("R1 bus_err", 32'(bus_err), 0);
        check("R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_window;
        logic [31:0] pa;
        logic        err;
        int          lat, nrd;
        access(32'h8000_1234, 3'd1, 1'b0, 1'b0, pa, err, lat, nrd);
        check("R2 win0 latency", 32'(lat), 0);
        check("R2 win0 reads", 32'(nrd), 0);
        check("R2 win0 phys", pa, 32'h8000_1234);
        // supervisor code misses the user-only window and faults at an empty root slot
        expect_walk("R2 win0 fc miss", 32'h8000_1234, 3'd5, 1'b0, 1'b0, 32'h8000_1234, 1'b1, 1);
        access(32'h1F00_4000, 3'd5, 1'b0, 1'b0, pa, err, lat, nrd);
        check("R2 win1 masked hit latency", 32'(lat), 0);
        check("R2 win1 masked hit err", 32'(err), 0);
        expect_walk("R2 win1 mask miss", 32'h2F00_0000, 3'd5, 1'b0, 1'b0, 32'h2F00_0000, 1'b1, 1);
        expect_walk("R2 win1 fc miss", 32'h1F00_4000, 3'd1, 1'b0, 1'b0, 32'h1F00_4000, 1'b1, 1);
    endtask

    task automatic t_window_wp;
        expect_walk("R3 win1 write", 32'h1F00_4000, 3'd5, 1'b1, 1'b0, 32'h1F00_4000, 1'b1, 0);
        expect_walk("R3 win1 probe write", 32'h1F00_4000, 3'd5, 1'b1, 1'b1, 32'h1F00_4000, 1'b0, 0);
        expect_walk("R3 win0 write no wp", 32'h8000_0010, 3'd1, 1'b1, 1'b0, 32'h8000_0010, 1'b0, 0);
    endtask

    task automatic t_small_page;
        big_page = 1'b0;
        expect_walk("R4 R5 4k read", 32'h0204_5678, 3'd1, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 3);
        expect_walk("R5 4k write", 32'h0204_5678, 3'd1, 1'b1, 1'b0, 32'h1234_5678, 1'b0, 3);
    endtask

    task automatic t_big_page;
        big_page = 1'b1;
        expect_walk("R6 8k read", 32'h0204_5678, 3'd1, 1'b0, 1'b0,
                    (32'hABCD_E001 & 32'hFFFF_E000) | (32'h0204_5678 & 32'h0000_1FFF), 1'b0, 3);
        big_page = 1'b0;
    endtask

    task automatic t_invalid;
        expect_walk("R7 root invalid", 32'h0800_0000, 3'd1, 1'b0, 1'b0, 32'h0800_0000, 1'b1, 1);
        expect_walk("R7 root invalid probe", 32'h0800_0000, 3'd1, 1'b0, 1'b1, 32'h0800_0000, 1'b0, 1);
        expect_walk("R7 ptr invalid", 32'h0A08_5678, 3'd1, 1'b0, 1'b0, 32'h0A08_5678, 1'b1, 2);
        expect_walk("R9 page invalid", 32'h0204_7678, 3'd1, 1'b0, 1'b0, 32'h0204_7678, 1'b1, 3);
        expect_walk("R9 page invalid probe", 32'h0204_7678, 3'd1, 1'b0, 1'b1, 32'h0204_7678, 1'b0, 3);
    endtask

    task automatic t_wp_levels;
        expect_walk("R8 root wp write", 32'h0404_5678, 3'd1, 1'b1, 1'b0, 32'h0404_5678, 1'b1, 1);
        expect_walk("R8 root wp read", 32'h0404_5678, 3'd1, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 3);
        expect_walk("R8 ptr wp write", 32'h0604_5678, 3'd1, 1'b1, 1'b0, 32'h0604_5678, 1'b1, 2);
        expect_walk("R8 ptr wp probe write", 32'h0604_5678, 3'd1, 1'b1, 1'b1, 32'h1234_5678, 1'b0, 3);
    endtask

    task automatic t_indirect;
        expect_walk("R10 one hop", 32'h0204_6678, 3'd1, 1'b0, 1'b0, 32'h5555_5678, 1'b0, 4);
        expect_walk("R10 chain", 32'h0204_8678, 3'd1, 1'b0, 1'b0, 32'h0204_8678, 1'b1, 4);
        expect_walk("R10 chain probe", 32'h0204_8678, 3'd1, 1'b0, 1'b1, 32'h0204_8678, 1'b1, 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[32'h004 >> 2] = 32'h0000_0202;   // root 1 -> ptr table 0x200
        mem[32'h008 >> 2] = 32'h0000_0206;   // root 2, write-protected
        mem[32'h00C >> 2] = 32'h0000_0602;   // root 3 -> ptr table 0x600
        mem[32'h014 >> 2] = 32'h0000_0602;   // root 5 -> ptr table 0x600
        mem[32'h204 >> 2] = 32'h0000_0402;   // ptr 1 -> page table 0x400
        mem[32'h604 >> 2] = 32'h0000_0406;   // ptr 1, write-protected
        mem[32'h408 >> 2] = 32'hABCD_E001;   // 8k index 2
        mem[32'h414 >> 2] = 32'h1234_5001;   // 4k index 5
        mem[32'h418 >> 2] = 32'h0000_0802;   // 4k index 6, indirect
        mem[32'h420 >> 2] = 32'h0000_0812;   // 4k index 8, indirect
        mem[32'h800 >> 2] = 32'h5555_5001;
        mem[32'h810 >> 2] = 32'h0000_0802;   // indirect again
        root_ptr = 32'h0000_0000;
        win0 = 32'h8000_8000;                // base 0x80, user only
        win1 = 32'h100F_A004;                // base 0x10 mask 0x0F, supervisor, wp
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_window();
        t_window_wp();
        t_small_page();
        t_big_page();
        t_invalid();
        t_wp_levels();
        t_indirect();
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule